// File: doc/BRIEF.md
# SD Host Command Issue Controller

This block sequences commands on the CMD line of an SD/MMC host. Software programs an argument word and then a command word whose top bit is a start request. The controller derives a card clock from the system clock, shifts out a 48-bit command frame with its CRC7, and, if asked to, collects the card's reply into four response words. It raises a done flag and one flag per reply error.

A clock divider and a clock enable are written into a holding register. They reach the card clock only when a command with the clock-update flag set is issued. That command never drives the CMD line. Two optional steps can come before a command: a wait while the card signals busy, and a run of idle clocks with CMD driven high for card initialisation. Data-line transfers are not part of this block.

Register map on `wr_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | argument | 32-bit command argument |
| 1 | command | fields listed in the requirements |
| 2 | clock control | divider in the low `DIV_W` bits, enable at bit 16 |
| 3 | bus width | two-bit width code |

The card clock toggles once every `div+1` system cycles.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, `card_clk` is 0, `cmd_oe` is 0, `cmd_out` is 1, `cmd_word` is 0 and all four flags are 0.
- R2: A write to clock control is held back and does not change the card clock. A command with bit 21 set applies the held divider and enable, clears bit 31 of `cmd_word`, and leaves `cmd_oe` at 0 throughout.
- R3: A command frame is 48 bits sent MSB first: a 0, a 1, the index (command bits 5:0), the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over the first 40 bits, and a 1. `cmd_out` changes only on falling card-clock edges.
- R4: Bit 31 of `cmd_word` stays 1 from the load write until the command ends. It then clears and `cmd_done` rises. Writes to the argument or command register while bit 31 is set are ignored.
- R5: With bit 6 clear, the command ends right after the end bit is sent, and no error flag is set.
- R6: With bit 6 set and bit 7 clear, a 48-bit reply is sampled on rising card-clock edges. `resp0` receives reply bits 39:8.
- R7: With bits 6 and 7 set, a 136-bit reply is taken. Reply bits 127:0 fill `resp3..resp0`, and `resp0` holds the least-significant bits.
- R8: With bit 8 set, a CRC7 mismatch in the reply sets `rsp_crc_err`. With bit 8 clear, no CRC error is ever flagged. For a long reply the CRC covers bits 127:8; for a short reply it covers bits 47:8. It is compared against bits 7:1.
- R9: A reply whose final bit is 0 sets `rsp_end_err`.
- R10: If no start bit arrives within `RSP_TMO` (64) rising card-clock edges after the frame, `rsp_timeout` is set and the command ends. A reply starting earlier is accepted.
- R11: With bit 15 set, CMD is driven high for `INIT_CLKS` (80) card clocks before the start bit.
- R12: With bit 13 set, nothing is sent while `busy_in` is 1.
- R13: `bus_width` presents the width code last written (0 one line, 1 four lines, 2 eight lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| cmd_in | input | 1 | CMD line as seen from the card |
| busy_in | input | 1 | Card busy indication |
| cmd_word | output | 32 | Command register readback, bit 31 pending |
| card_clk | output | 1 | Card clock |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| bus_width | output | 2 | Bus width code |
| resp0 | output | 32 | Response word 0 (least significant) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| cmd_done | output | 1 | Command finished |
| rsp_timeout | output | 1 | No reply start bit |
| rsp_crc_err | output | 1 | Reply CRC mismatch |
| rsp_end_err | output | 1 | Reply end bit was 0 |

## Verification
The bench aims at the points where a plausible design slips.

- **Frame CRC.** Frames are compared with published CRC7 values. A wrong polynomial or seed, or a CRC taken over the wrong bits, would mismatch.
- **Timeout window.** A reply delayed by 50 clocks must pass, while a missing reply must time out. An off-by-one or inverted count would either flag a good reply or hang.
- **Long-reply word order.** Reversed word order would swap `resp0` and `resp3`.
- **CRC check bit.** A design that ignored bit 8 would flag R3-style replies.
- **Side effects.** The clock-update command must stay silent on CMD. A command word written mid-command must not change the frame on the wire.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int DIV_W     = 8,
  parameter int INIT_CLKS = 80,
  parameter int RSP_TMO   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        cmd_in,
  input  logic        busy_in,
  output logic [31:0] cmd_word,
  output logic        card_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic [1:0]  bus_width,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic        cmd_done,
  output logic        rsp_timeout,
  output logic        rsp_crc_err,
  output logic        rsp_end_err
);
  localparam int TMO_W = $clog2(RSP_TMO + 1);
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] FRAME_BITS = CNT_W'(48);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(135);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(47);
  localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_CLKS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST   = TMO_W'(RSP_TMO - 1);

  typedef enum logic [2:0] {S_IDLE, S_WBUSY, S_INIT, S_TX, S_WRSP, S_RX} st_t;
  st_t state;

  logic [31:0]       arg_q;
  logic [DIV_W-1:0]  div_pend, div_q, div_cnt;
  logic              en_pend, en_q;
  logic [47:0]       tx_sh;
  logic [134:0]      rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic [TMO_W-1:0]  tmo;

  function automatic logic [6:0] crc7(input logic [119:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  wire         tick  = en_q && (div_cnt == div_q);
  wire         rise  = tick && !card_clk;
  wire         fall  = tick && card_clk;
  wire [135:0] rx_nx = {rx_sh, cmd_in};
  wire [6:0]   rx_crc = crc7(cmd_word[7] ? rx_nx[127:8] : {80'b0, rx_nx[47:8]});
  wire [6:0]   tx_crc = crc7({80'b0, 2'b01, cmd_word[5:0], arg_q});
  wire [CNT_W-1:0] rx_last = cmd_word[7] ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      arg_q <= '0; cmd_word <= '0;
      div_pend <= '0; div_q <= '0; div_cnt <= '0;
      en_pend <= 1'b0; en_q <= 1'b0; card_clk <= 1'b0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0; bus_width <= '0;
      tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0; tmo <= '0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0;
      cmd_done <= 1'b0; rsp_timeout <= 1'b0; rsp_crc_err <= 1'b0; rsp_end_err <= 1'b0;
    end else begin
      if (!en_q) begin
        div_cnt <= '0; card_clk <= 1'b0;
      end else if (tick) begin
        div_cnt <= '0; card_clk <= ~card_clk;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end

      if (wr_en) begin
        case (wr_addr)
          2'd0: if (!cmd_word[31]) arg_q <= wr_data;
          2'd1: if (!cmd_word[31]) begin
            cmd_word <= wr_data;
            if (wr_data[31]) begin
              cmd_done <= 1'b0; rsp_timeout <= 1'b0;
              rsp_crc_err <= 1'b0; rsp_end_err <= 1'b0;
            end
          end
          2'd2: begin div_pend <= wr_data[DIV_W-1:0]; en_pend <= wr_data[16]; end
          default: bus_width <= wr_data[1:0];
        endcase
      end

      case (state)
        S_IDLE: if (cmd_word[31]) begin
          if (cmd_word[21]) begin
            div_q <= div_pend; en_q <= en_pend; cmd_word[31] <= 1'b0;
          end else begin
            tx_sh   <= {2'b01, cmd_word[5:0], arg_q, tx_crc, 1'b1};
            bit_cnt <= '0;
            state   <= cmd_word[13] ? S_WBUSY : (cmd_word[15] ? S_INIT : S_TX);
          end
        end
        S_WBUSY: if (!busy_in) state <= cmd_word[15] ? S_INIT : S_TX;
        S_INIT: if (fall) begin
          cmd_oe <= 1'b1; cmd_out <= 1'b1;
          if (bit_cnt == INIT_LAST) begin bit_cnt <= '0; state <= S_TX; end
          else bit_cnt <= bit_cnt + 1'b1;
        end
        S_TX: if (fall) begin
          if (bit_cnt == FRAME_BITS) begin
            cmd_oe <= 1'b0; cmd_out <= 1'b1; tmo <= '0; bit_cnt <= '0;
            if (cmd_word[6]) state <= S_WRSP;
            else begin state <= S_IDLE; cmd_word[31] <= 1'b0; cmd_done <= 1'b1; end
          end else begin
            cmd_oe <= 1'b1; cmd_out <= tx_sh[47];
            tx_sh <= {tx_sh[46:0], 1'b0}; bit_cnt <= bit_cnt + 1'b1;
          end
        end
        S_WRSP: if (rise) begin
          if (!cmd_in) begin
            rx_sh <= rx_nx[134:0]; bit_cnt <= CNT_W'(1); state <= S_RX;
          end else if (tmo == TMO_LAST) begin
            rsp_timeout <= 1'b1; cmd_word[31] <= 1'b0; cmd_done <= 1'b1; state <= S_IDLE;
          end else tmo <= tmo + 1'b1;
        end
        S_RX: if (rise) begin
          rx_sh   <= rx_nx[134:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == rx_last) begin
            if (cmd_word[7]) begin
              resp0 <= rx_nx[31:0];  resp1 <= rx_nx[63:32];
              resp2 <= rx_nx[95:64]; resp3 <= rx_nx[127:96];
            end else resp0 <= rx_nx[39:8];
            rsp_crc_err  <= cmd_word[8] && (rx_crc != rx_nx[7:1]);
            rsp_end_err  <= !rx_nx[0];
            cmd_word[31] <= 1'b0; cmd_done <= 1'b1; state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_update_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cmd_word[31] && cmd_word[21]) |=> (!cmd_oe && state == S_IDLE));
  a_r3_cmd_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_out) |-> $fell(card_clk));
  a_r4_done_clears_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> !cmd_word[31]);
  a_r10_timeout_alone: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> !(rsp_crc_err || rsp_end_err));
  a_r12_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WBUSY) |-> !cmd_oe);
  a_r2_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !card_clk);
endmodule

// File: tb/sd_cmd_issuer_test.sv
module sd_cmd_issuer_test;
  logic clk = 0, rst_n = 0, wr_en = 0, cmd_in = 1, busy_in = 0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_word, resp0, resp1, resp2, resp3;
  logic card_clk, cmd_out, cmd_oe, cmd_done, rsp_timeout, rsp_crc_err, rsp_end_err;
  logic [1:0] bus_width;
  int errors = 0, checks = 0;

  sd_cmd_issuer uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cmd_in, .busy_in,
    .cmd_word, .card_clk, .cmd_out, .cmd_oe, .bus_width, .resp0, .resp1, .resp2, .resp3,
    .cmd_done, .rsp_timeout, .rsp_crc_err, .rsp_end_err);

  always #2 clk = ~clk;

  localparam logic [44:0] VEC [4] = '{
    {6'd0,  32'h0000_0000, 7'h4A},
    {6'd17, 32'h0000_0000, 7'h2A},
    {6'd8,  32'h0000_01AA, 7'h43},
    {6'd55, 32'h0000_0000, 7'h32}};

  function automatic logic [6:0] ref_crc(input logic [119:0] d);
    logic [6:0] c = '0;
    for (int i = 119; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic grab(output logic [47:0] f, output int pre);
    int guard = 0;
    pre = 0; f = '0;
    while (guard < 3000) begin
      @(posedge card_clk); @(negedge clk);
      if (cmd_oe && !cmd_out) break;
      if (cmd_oe) pre++;
      guard++;
    end
    for (int i = 46; i >= 0; i--) begin
      @(posedge card_clk); @(negedge clk); f[i] = cmd_out;
    end
  endtask

  task automatic reply(input logic [135:0] r, input int len, input int dly);
    repeat (dly) @(negedge card_clk);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge card_clk); #1 cmd_in = r[i];
    end
    @(negedge card_clk); #1 cmd_in = 1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !cmd_done; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] f, ef;
    logic [135:0] r;
    logic [119:0] body;
    int pre;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!card_clk && !cmd_oe && cmd_out && cmd_word == 0 && !cmd_done &&
          !rsp_timeout && !rsp_crc_err && !rsp_end_err, "R1 reset",
          {card_clk, cmd_oe, cmd_out, cmd_done}, 4'b0010);

    // R2: held clock setting, then silent update
    wr(2'd2, 32'h0001_0001);
    seen = 0;
    repeat (20) begin @(negedge clk); if (card_clk) seen = 1; end
    check(!seen, "R2 held clock not applied", seen, 0);
    wr(2'd1, 32'h8020_0000);
    seen = 0;
    repeat (10) begin @(negedge clk); if (cmd_oe) seen = 1; end
    check(!seen && !cmd_word[31], "R2 update silent and load cleared", {seen, cmd_word[31]}, 0);
    seen = 0;
    repeat (10) begin @(negedge clk); if (card_clk) seen = 1; end
    check(seen, "R2 clock running after update", seen, 1);

    // R3/R5: vector table of frames without reply
    for (int v = 0; v < 4; v++) begin
      check(ref_crc({80'b0, 2'b01, VEC[v][44:7]}) == VEC[v][6:0], "R3 bench crc model",
            ref_crc({80'b0, 2'b01, VEC[v][44:7]}), VEC[v][6:0]);
      wr(2'd0, VEC[v][38:7]);
      wr(2'd1, 32'h8000_0000 | 32'(VEC[v][44:39]));
      grab(f, pre);
      check(f == {2'b01, VEC[v], 1'b1}, "R3 frame", f, {2'b01, VEC[v], 1'b1});
      wait_done();
      check(cmd_done && !cmd_word[31] && !rsp_timeout && !rsp_crc_err && !rsp_end_err,
            "R5 no-reply completion", {cmd_done, cmd_word[31], rsp_timeout}, 3'b100);
    end

    // R4/R6/R8: short reply, good CRC; overwrite attempt while pending
    wr(2'd0, 32'h0000_0200);
    wr(2'd1, 32'h8000_0151);
    check(cmd_word[31] == 1'b1, "R4 load held", cmd_word[31], 1);
    wr(2'd1, 32'h8000_0005);
    wr(2'd0, 32'hFFFF_FFFF);
    grab(f, pre);
    ef = {2'b01, 6'd17, 32'h0000_0200, ref_crc({80'b0, 2'b01, 6'd17, 32'h0000_0200}), 1'b1};
    check(f == ef, "R4 writes while pending ignored", f, ef);
    r = '0;
    r[47:0] = {2'b00, 6'd17, 32'h0000_0900, ref_crc({80'b0, 2'b00, 6'd17, 32'h0000_0900}), 1'b1};
    reply(r, 48, 2);
    wait_done();
    check(resp0 == 32'h0000_0900 && !rsp_crc_err && !rsp_end_err && !rsp_timeout,
          "R6 short reply captured", resp0, 32'h0000_0900);

    // R8: bad CRC with check enabled
    wr(2'd1, 32'h8000_0151);
    grab(f, pre);
    r[1] = ~r[1];
    reply(r, 48, 2);
    wait_done();
    check(rsp_crc_err, "R8 crc mismatch flagged", rsp_crc_err, 1);

    // R8: check disabled, same bad reply
    wr(2'd1, 32'h8000_0041);
    grab(f, pre);
    reply(r, 48, 2);
    wait_done();
    check(cmd_done && !rsp_crc_err, "R8 crc ignored when check bit clear", rsp_crc_err, 0);

    // R9: bad end bit
    wr(2'd1, 32'h8000_0151);
    grab(f, pre);
    r[1] = ~r[1]; r[0] = 1'b0;
    reply(r, 48, 2);
    wait_done();
    check(rsp_end_err && !rsp_crc_err, "R9 end bit error", {rsp_end_err, rsp_crc_err}, 2'b10);

    // R7: long reply
    body = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    r = {2'b00, 6'b111111, body, ref_crc(body), 1'b1};
    wr(2'd1, 32'h8000_01C2);
    grab(f, pre);
    reply(r, 136, 3);
    wait_done();
    check({resp3, resp2, resp1, resp0} == r[127:0] && !rsp_crc_err && !rsp_end_err,
          "R7 long reply word order", {resp3, resp2, resp1, resp0}, r[127:0]);

    // R10: late but in-window reply, then no reply
    r = '0;
    r[47:0] = {2'b00, 6'd13, 32'h0000_0A5A, ref_crc({80'b0, 2'b00, 6'd13, 32'h0000_0A5A}), 1'b1};
    wr(2'd1, 32'h8000_014D);
    grab(f, pre);
    reply(r, 48, 50);
    wait_done();
    check(!rsp_timeout && resp0 == 32'h0000_0A5A, "R10 reply inside window", {rsp_timeout, resp0}, 32'h0000_0A5A);
    wr(2'd1, 32'h8000_014D);
    grab(f, pre);
    wait_done();
    check(cmd_done && rsp_timeout, "R10 timeout", {cmd_done, rsp_timeout}, 2'b11);

    // R11: initialisation clocks
    wr(2'd1, 32'h8000_8000);
    grab(f, pre);
    check(pre == 80, "R11 init clocks", pre, 80);
    wait_done();

    // R12: busy wait
    busy_in = 1;
    wr(2'd1, 32'h8000_2007);
    seen = 0;
    repeat (60) begin @(negedge clk); if (cmd_oe) seen = 1; end
    check(!seen && cmd_word[31], "R12 held while busy", seen, 0);
    busy_in = 0;
    grab(f, pre);
    check(f[45:40] == 6'd7, "R12 sent after busy", f[45:40], 7);
    wait_done();

    // R13: bus width code
    wr(2'd3, 32'd2);
    check(bus_width == 2'd2, "R13 width code eight lines", bus_width, 2);
    wr(2'd3, 32'd1);
    check(bus_width == 2'd1, "R13 width code four lines", bus_width, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule